// File: doc/BRIEF.md
# Post-Scaler with Fifty-Percent Load Clock Divider

This block sits in a clock path behind a fast oscillator. A two-bit select picks what appears on the post-scaled clock output. The choices are the oscillator clock itself, the clock divided by two, the clock divided by four, or a static auxiliary bit. A second divider is driven by that post-scaled clock and produces a slower load clock. A three-bit code sets its modulus to 3, 4, 5, 6, 8 or 10.

The load clock keeps an exact 50/50 duty cycle for every modulus, the odd ones included. For an odd modulus, the output is the OR of a phase held by the rising-edge counter and a copy of that phase delayed by half a post-scaled period. The copy is taken on the falling edge of the post-scaled clock. All logic runs on the oscillator clock and its falling edge. The divided rates are carried as synchronous rise and fall enables instead of derived clocks, which is how glitch-free clock muxing is approximated here.

Top module: `clk_postscale_loaddiv`

## Requirements
- R1: With select 0, `postClk` follows `clk` (high and low one half oscillator period each) while reset is released.
- R2: With select 1, `postClk` is the oscillator clock divided by 2 (high 2 and low 2 half periods). With select 2, it is divided by 4 (high 4 and low 4 half periods).
- R3: With select 3, `postClk` equals `auxBit` as sampled at the previous `clk` rising edge.
- R4: The modulus code maps 0→3, 1→4, 2→5, 3→6, 4→8 and 5→10. Codes 6 and 7 both mean 10.
- R5: For every modulus N, the load clock is high for exactly N/2 post-scaled periods and low for exactly N/2 post-scaled periods, including N = 3 and N = 5.
- R6: The load divider counts post-scaled clock periods, so the load period in oscillator cycles is N times the post-scaler divisor (1, 2 or 4).
- R7: A new modulus code is taken only at the next rising edge of the load clock. The load period already under way finishes with the old modulus.
- R8: While select 3 is active, the load clock holds its level whatever `auxBit` and the modulus code do.
- R9: While `rstN` is low, both `postClk` and `loadClk` are 0.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast oscillator clock |
| rstN | input | 1 | Asynchronous active-low reset |
| postSel | input | 2 | Post-scaler select: 0 direct, 1 divide by 2, 2 divide by 4, 3 auxiliary bit |
| auxBit | input | 1 | Static level driven out when select 3 is active |
| modCode | input | 3 | Load divider modulus code (see R4) |
| postClk | output | 1 | Post-scaled clock |
| loadClk | output | 1 | 50% duty load clock derived from the post-scaled clock |

## Verification
A wrong phase counter or high-count threshold in the load divider shows within one load period as unequal high and low run lengths on `loadClk`. Measuring each run in half oscillator periods catches an off-by-one even for the odd moduli. A fault in the half-period delayed copy only affects odd moduli, where one half-period unit moves from the high time to the low time. A wrong enable in the post-scaler shows within four oscillator cycles as a wrong run length on `postClk`, and then scales every load period by the wrong divisor. A premature modulus latch appears in the very period during which the code is changed.

// File: rtl/psl_pkg.sv
package psl_pkg;

  localparam int SEL_W  = 2;
  localparam int CODE_W = 3;
  localparam int CNT_W  = 4;
  localparam int PRE_W  = 2;

  typedef enum logic [SEL_W-1:0] {
    SEL_DIRECT  = 2'd0,
    SEL_HALF    = 2'd1,
    SEL_QUARTER = 2'd2,
    SEL_AUX     = 2'd3
  } postSel_e;

  // enables handed from the post-scaler control to the load divider
  typedef struct packed {
    logic riseTick;   // post-scaled clock rises at this clk edge
    logic fallTick;   // post-scaled clock falls at this clk edge (divided modes)
    logic fullRate;   // direct mode: falling copy is taken on clk negedge
  } strobes_t;

  function automatic logic [CNT_W-1:0] modulusOf(input logic [CODE_W-1:0] code);
    logic [CNT_W-1:0] n;
    case (code)
      3'd0:    n = CNT_W'(3);
      3'd1:    n = CNT_W'(4);
      3'd2:    n = CNT_W'(5);
      3'd3:    n = CNT_W'(6);
      3'd4:    n = CNT_W'(8);
      default: n = CNT_W'(10);
    endcase
    return n;
  endfunction

endpackage

// File: rtl/psl_postscale_ctrl.sv
module psl_postscale_ctrl
  import psl_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [SEL_W-1:0]  postSel,
  input  logic              auxBit,
  output strobes_t          strobes,
  output logic              postClk
);

  postSel_e         selQ;
  logic [PRE_W-1:0] divCnt;
  logic [PRE_W-1:0] divNext;
  logic             postReg;

  assign divNext = divCnt + PRE_W'(1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selQ    <= SEL_DIRECT;
      divCnt  <= '0;
      postReg <= 1'b0;
    end else begin
      selQ   <= postSel_e'(postSel);
      divCnt <= divNext;
      case (selQ)
        SEL_HALF:    postReg <= divNext[0];
        SEL_QUARTER: postReg <= divNext[PRE_W-1];
        SEL_AUX:     postReg <= auxBit;
        default:     postReg <= 1'b0;
      endcase
    end
  end

  always_comb begin
    strobes = '0;
    case (selQ)
      SEL_DIRECT: begin
        strobes.riseTick = 1'b1;
        strobes.fullRate = 1'b1;
      end
      SEL_HALF: begin
        strobes.riseTick = (divCnt[0] == 1'b0);
        strobes.fallTick = (divCnt[0] == 1'b1);
      end
      SEL_QUARTER: begin
        strobes.riseTick = (divCnt == PRE_W'(1));
        strobes.fallTick = (divCnt == PRE_W'(3));
      end
      default: strobes = '0;
    endcase
  end

  // direct mode passes the oscillator clock, gated low during reset
  assign postClk = (selQ == SEL_DIRECT) ? (clk & rstN) : postReg;

  assert_half_phase_R2: assert property (@(posedge clk) disable iff (!rstN)
    ($past(selQ) == SEL_HALF) |-> (postReg == divCnt[0]));

  assert_quarter_phase_R2: assert property (@(posedge clk) disable iff (!rstN)
    ($past(selQ) == SEL_QUARTER) |-> (postReg == divCnt[PRE_W-1]));

  assert_aux_follow_R3: assert property (@(posedge clk) disable iff (!rstN)
    ($past(selQ) == SEL_AUX) |-> (postReg == $past(auxBit)));

endmodule

// File: rtl/psl_loaddiv.sv
module psl_loaddiv
  import psl_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          strobes,
  input  logic [CODE_W-1:0] modCode,
  output logic              loadClk
);

  logic [CODE_W-1:0] activeCode;
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  activeN;
  logic [CNT_W-1:0]  useN;
  logic [CNT_W-1:0]  nextCnt;
  logic [CNT_W-1:0]  hiCount;
  logic              started;
  logic              wrap;
  logic              aReg;
  logic              aNext;
  logic              bPos;
  logic              bNeg;
  logic              bSel;
  logic              isOdd;

  assign activeN = modulusOf(activeCode);
  assign wrap    = !started || (cnt == activeN - CNT_W'(1));
  assign useN    = wrap ? modulusOf(modCode) : activeN;
  assign nextCnt = wrap ? '0 : cnt + CNT_W'(1);
  assign hiCount = useN >> 1;          // N/2 even, (N-1)/2 odd
  assign aNext   = (nextCnt < hiCount);
  assign isOdd   = activeN[0];

  // rising-edge phase, advanced once per post-scaled period
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt        <= '0;
      started    <= 1'b0;
      aReg       <= 1'b0;
      activeCode <= '0;
    end else if (strobes.riseTick) begin
      cnt     <= nextCnt;
      aReg    <= aNext;
      started <= 1'b1;
      if (wrap) activeCode <= modCode;
    end
  end

  // half-period copy for divided modes: taken where the post clock falls
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 bPos <= 1'b0;
    else if (strobes.fallTick) bPos <= aReg;
  end

  // half-period copy for direct mode: taken on the oscillator falling edge
  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN)                 bNeg <= 1'b0;
    else if (strobes.fullRate) bNeg <= aReg;
  end

  assign bSel    = strobes.fullRate ? bNeg : bPos;
  assign loadClk = isOdd ? (aReg | bSel) : aReg;

  assert_cnt_range_R4: assert property (@(posedge clk) disable iff (!rstN)
    started |-> (cnt < activeN));

  assert_wrap_high_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.riseTick && wrap) |=> aReg);

  assert_mod_latch_R7: assert property (@(posedge clk) disable iff (!rstN)
    !(strobes.riseTick && wrap) |=> $stable(activeCode));

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.riseTick |=> ($stable(cnt) && $stable(aReg)));

endmodule

// File: rtl/clk_postscale_loaddiv.sv
module clk_postscale_loaddiv
  import psl_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [SEL_W-1:0]  postSel,
  input  logic              auxBit,
  input  logic [CODE_W-1:0] modCode,
  output logic              postClk,
  output logic              loadClk
);

  strobes_t strobes;

  psl_postscale_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .postSel (postSel),
    .auxBit  (auxBit),
    .strobes (strobes),
    .postClk (postClk)
  );

  psl_loaddiv u_div (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .modCode (modCode),
    .loadClk (loadClk)
  );

endmodule

// File: tb/clk_postscale_loaddiv_bench.sv
module clk_postscale_loaddiv_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] postSel = 2'd1;
  logic       auxBit = 1'b0;
  logic [2:0] modCode = 3'd0;
  logic       postClk;
  logic       loadClk;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;   // 125 MHz

  clk_postscale_loaddiv u_clk_postscale_loaddiv (
    .clk(clk), .rstN(rstN), .postSel(postSel), .auxBit(auxBit),
    .modCode(modCode), .postClk(postClk), .loadClk(loadClk)
  );

  // sel[11:10], code[9:7], expected half-periods high (= low) [6:0]
  localparam int NVEC = 14;
  localparam logic [11:0] VEC [NVEC] = '{
    {2'd0, 3'd0, 7'd3},  {2'd0, 3'd1, 7'd4},  {2'd0, 3'd2, 7'd5},
    {2'd0, 3'd3, 7'd6},  {2'd0, 3'd4, 7'd8},  {2'd0, 3'd5, 7'd10},
    {2'd0, 3'd6, 7'd10}, {2'd0, 3'd7, 7'd10}, {2'd1, 3'd0, 7'd6},
    {2'd1, 3'd2, 7'd10}, {2'd1, 3'd3, 7'd12}, {2'd2, 3'd0, 7'd12},
    {2'd2, 3'd2, 7'd20}, {2'd2, 3'd5, 7'd40}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk or negedge clk);
    #1;
  endtask

  function automatic logic probe(input bit usePost);
    return usePost ? postClk : loadClk;
  endfunction

  task automatic waitRise(input bit usePost);
    logic prev;
    prev = probe(usePost);
    for (int i = 0; i < 600; i++) begin
      step();
      if (!prev && probe(usePost)) return;
      prev = probe(usePost);
    end
  endtask

  task automatic countRun(input bit usePost, input logic lvl, output int n);
    n = 0;
    while (probe(usePost) == lvl && n < 600) begin
      n++;
      step();
    end
  endtask

  task automatic measure(input bit usePost, output int hi, output int lo);
    waitRise(usePost);
    countRun(usePost, 1'b1, hi);
    countRun(usePost, 1'b0, lo);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      summary();
      $finish;
    end
  end

  initial begin
    int hi, lo, hi2;
    logic held;
    int changes;

    // R9: reset state in a divided mode and in direct mode
    repeat (3) @(posedge clk);
    #1;
    check("R9 loadClk in reset", int'(loadClk), 0);
    check("R9 postClk in reset sel1", int'(postClk), 0);
    postSel = 2'd0;
    @(posedge clk); #1;
    check("R9 postClk in reset sel0", int'(postClk), 0);
    @(negedge clk); #1;
    check("R9 postClk in reset sel0 low phase", int'(postClk), 0);
    rstN = 1'b1;
    repeat (4) @(posedge clk); #1;

    // R1, R2: post-scaled clock run lengths
    measure(1'b1, hi, lo);
    check("R1 postClk high sel0", hi, 1);
    check("R1 postClk low sel0", lo, 1);
    postSel = 2'd1;
    repeat (6) @(posedge clk); #1;
    measure(1'b1, hi, lo);
    check("R2 postClk high div2", hi, 2);
    check("R2 postClk low div2", lo, 2);
    postSel = 2'd2;
    repeat (6) @(posedge clk); #1;
    measure(1'b1, hi, lo);
    check("R2 postClk high div4", hi, 4);
    check("R2 postClk low div4", lo, 4);

    // R4, R5, R6: every modulus and divisor from the vector table
    for (int v = 0; v < NVEC; v++) begin
      postSel = VEC[v][11:10];
      modCode = VEC[v][9:7];
      repeat (100) @(posedge clk); #1;
      measure(1'b0, hi, lo);
      check($sformatf("R5 R4 R6 high sel%0d code%0d", VEC[v][11:10], VEC[v][9:7]),
            hi, int'(VEC[v][6:0]));
      check($sformatf("R5 R4 R6 low sel%0d code%0d", VEC[v][11:10], VEC[v][9:7]),
            lo, int'(VEC[v][6:0]));
    end

    // R7: change right after a load rising edge; the running period keeps N=3
    postSel = 2'd1;
    modCode = 3'd0;
    repeat (100) @(posedge clk); #1;
    waitRise(1'b0);
    modCode = 3'd4;
    countRun(1'b0, 1'b1, hi);
    countRun(1'b0, 1'b0, lo);
    countRun(1'b0, 1'b1, hi2);
    check("R7 old high kept", hi, 6);
    check("R7 old low kept", lo, 6);
    check("R7 new high after edge", hi2, 16);

    // R3: auxiliary bit drives postClk one clk later
    postSel = 2'd3;
    auxBit = 1'b1;
    repeat (3) @(posedge clk); #1;
    check("R3 postClk aux high", int'(postClk), 1);
    auxBit = 1'b0;
    repeat (2) @(posedge clk); #1;
    check("R3 postClk aux low", int'(postClk), 0);

    // R8: load clock frozen in aux mode while aux and code move
    held = loadClk;
    changes = 0;
    for (int k = 0; k < 80; k++) begin
      if (k % 7 == 0) auxBit = ~auxBit;
      if (k % 11 == 0) modCode = modCode + 3'd1;
      step();
      if (loadClk != held) changes++;
    end
    check("R8 loadClk toggles in aux mode", changes, 0);

    // R9: reset reasserted mid-run clears load clock
    postSel = 2'd1;
    modCode = 3'd5;
    repeat (30) @(posedge clk); #1;
    rstN = 1'b0;
    #1;
    check("R9 loadClk after async reset", int'(loadClk), 0);
    check("R9 postClk after async reset", int'(postClk), 0);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule